// File: doc/BRIEF.md
# Frame-Driven Cipher Command Sequencer

This block runs a complete multi-block cipher frame from a single start pulse. The frame sits in a local block RAM whose words are one cipher block wide. The frame opens with a short header that describes the whole job: the cipher key, a key-length code, the direction (encrypt or decrypt) and the number of data blocks. The sequencer reads and decodes that header and hands the key, the length code and the direction to an external block-cipher engine through a key-load strobe. It waits for the engine's key expansion to finish. Then it walks the data blocks in ascending address order. For each block it reads the word, starts the engine on it, waits for the engine to go idle and writes the result back over the input word.

The cipher engine is not part of this block. The sequencer drives a load strobe and a start strobe, watches a busy flag and takes a result bus. A header with an illegal key-length code, or with more blocks than the RAM can hold, ends the job at once with an error flag. When the job finishes, done is pulsed for one cycle.

Top module: `cipher_frame_seq`

## Requirements
- R1: Header layout. RAM word 0 holds key bits [127:0] and word 1 holds key bits [255:128]. In word 2, bits [1:0] are the key-length code (00 = 128, 01 = 192, 10 = 256 bits), bit 4 is the direction (1 = decrypt) and bits [23:16] are the data-block count N. Data blocks occupy words 3 to 3+N-1. The key, code and direction are presented to the engine with a one-cycle engKeyLoad pulse.
- R2: No engStart is issued before the engine has dropped busy after key load. engStart is never raised while engBusy is high or together with engKeyLoad.
- R3: Each data block is read, handed to the engine on engBlockIn with engStart, and its engResult is written back to the same address. Header words and words outside the frame are never written, and a read and a write never occur in the same cycle.
- R4: Blocks are processed in ascending address order, exactly N of them.
- R5: Let start be sampled at edge 0. The engine holds busy for K cycles after key load and P cycles after each start. Done is then high in cycle K+7+N*(P+3), counting the cycle after edge 0 as cycle 1.
- R6: With N = 0, done is asserted right after key load completes (cycle K+7), with no engStart and no RAM write.
- R7: Key-length code 11 sets err together with done in cycle 5, with no key load, no engStart and no RAM write.
- R8: A block count above 253 (the RAM depth less the three header words) is handled exactly as in R7.
- R9: done is a one-cycle pulse. err holds its value until the next accepted start. seqBusy is high from the cycle after start up to and including the done cycle.
- R10: start is ignored while seqBusy is high. The frame in flight keeps its timing and result, and it produces a single done.
- R11: After reset, seqBusy, done, err, ramWrEn, ramRdEn, engKeyLoad and engStart are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame when idle |
| seqBusy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last frame had an illegal header |
| ramAddr | output | ADDR_W | Local RAM word address |
| ramRdEn | output | 1 | RAM read strobe (data on the next cycle) |
| ramRdData | input | BLK_W | RAM read data |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrData | output | BLK_W | RAM write data |
| engKeyLoad | output | 1 | Engine key-load strobe |
| engKey | output | 2*BLK_W | Cipher key to the engine |
| engKeyLen | output | 2 | Key-length code to the engine |
| engDecrypt | output | 1 | Direction to the engine, 1 = decrypt |
| engStart | output | 1 | Engine block-start strobe |
| engBlockIn | output | BLK_W | Block handed to the engine |
| engBusy | input | 1 | Engine is expanding the key or processing a block |
| engResult | input | BLK_W | Engine output block |

## Verification
The bench sweeps every legal key-length code against both directions and block counts of 0, 1, 2 and 5. Because the engine model folds the code and the direction into its result, a wrongly routed field or swapped key half shows up as corrupted blocks. The counts separate an off-by-one in the loop end, the zero-block exit and plain address stepping. A full frame of 253 blocks exercises the last legal address and the count boundary. Counts of 254 and code 11 confirm the early error exit leaves RAM untouched. A start pulse in the middle of a frame must change neither the cycle count nor the data.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_HDR2, S_DECODE,
    S_KLOAD, S_KWAIT, S_BRD, S_BGO, S_BWAIT, S_FIN
  } seqState_t;

  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic capKeyLo;
    logic capKeyHi;
    logic capCtl;
    logic decRem;
    logic setErr;
    logic clrErr;
  } seqStrobe_t;

endpackage

// File: rtl/cfs_datapath.sv
module cfs_datapath
  import cfs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 128,
  parameter int HDR_WORDS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           st,
  input  logic [BLK_W-1:0]     ramRdData,
  output logic [ADDR_W-1:0]    ramAddr,
  output logic [2*BLK_W-1:0]   keyOut,
  output logic [1:0]           keyLenOut,
  output logic                 decryptOut,
  output logic                 errOut,
  output logic                 remIsZero,
  output logic                 remIsOne,
  output logic                 ctlIllegal
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int MAX_BLOCKS = DEPTH - HDR_WORDS;
  localparam int LEN_LSB    = 0;
  localparam int DIR_BIT    = 4;
  localparam int CNT_LSB    = 16;

  logic [ADDR_W-1:0]  addrReg;
  logic [BLK_W-1:0]   keyLoReg;
  logic [BLK_W-1:0]   keyHiReg;
  logic [1:0]         lenReg;
  logic               dirReg;
  logic [ADDR_W-1:0]  remReg;
  logic               errReg;

  logic [1:0]         lenField;
  logic               dirField;
  logic [ADDR_W-1:0]  cntField;

  assign lenField = ramRdData[LEN_LSB +: 2];
  assign dirField = ramRdData[DIR_BIT];
  assign cntField = ramRdData[CNT_LSB +: ADDR_W];

  assign ctlIllegal = (lenField == 2'b11) || (int'(cntField) > MAX_BLOCKS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (st.clrAddr) begin
      addrReg <= '0;
    end else if (st.incAddr) begin
      addrReg <= addrReg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyLoReg <= '0;
      keyHiReg <= '0;
    end else begin
      if (st.capKeyLo) keyLoReg <= ramRdData;
      if (st.capKeyHi) keyHiReg <= ramRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0;
      dirReg <= 1'b0;
      remReg <= '0;
    end else if (st.capCtl) begin
      lenReg <= lenField;
      dirReg <= dirField;
      remReg <= cntField;
    end else if (st.decRem) begin
      remReg <= remReg - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errReg <= 1'b0;
    end else if (st.clrErr) begin
      errReg <= 1'b0;
    end else if (st.setErr) begin
      errReg <= 1'b1;
    end
  end

  assign ramAddr    = addrReg;
  assign keyOut     = {keyHiReg, keyLoReg};
  assign keyLenOut  = lenReg;
  assign decryptOut = dirReg;
  assign errOut     = errReg;
  assign remIsZero  = (remReg == '0);
  assign remIsOne   = (remReg == {{(ADDR_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/cfs_control.sv
module cfs_control
  import cfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       engBusy,
  input  logic       remIsZero,
  input  logic       remIsOne,
  input  logic       ctlIllegal,
  output seqStrobe_t st,
  output logic       ramRdEn,
  output logic       ramWrEn,
  output logic       engKeyLoad,
  output logic       engStart,
  output logic       done,
  output logic       seqBusy
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    st         = '0;
    ramRdEn    = 1'b0;
    ramWrEn    = 1'b0;
    engKeyLoad = 1'b0;
    engStart   = 1'b0;
    done       = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          st.clrAddr = 1'b1;
          st.clrErr  = 1'b1;
          nextState  = S_HDR0;
        end
      end
      S_HDR0: begin
        ramRdEn    = 1'b1;
        st.incAddr = 1'b1;
        nextState  = S_HDR1;
      end
      S_HDR1: begin
        ramRdEn     = 1'b1;
        st.incAddr  = 1'b1;
        st.capKeyLo = 1'b1;
        nextState   = S_HDR2;
      end
      S_HDR2: begin
        ramRdEn     = 1'b1;
        st.incAddr  = 1'b1;
        st.capKeyHi = 1'b1;
        nextState   = S_DECODE;
      end
      S_DECODE: begin
        st.capCtl = 1'b1;
        if (ctlIllegal) begin
          st.setErr = 1'b1;
          nextState = S_FIN;
        end else begin
          nextState = S_KLOAD;
        end
      end
      S_KLOAD: begin
        engKeyLoad = 1'b1;
        nextState  = S_KWAIT;
      end
      S_KWAIT: begin
        if (!engBusy) nextState = remIsZero ? S_FIN : S_BRD;
      end
      S_BRD: begin
        ramRdEn   = 1'b1;
        nextState = S_BGO;
      end
      S_BGO: begin
        engStart  = 1'b1;
        nextState = S_BWAIT;
      end
      S_BWAIT: begin
        if (!engBusy) begin
          ramWrEn    = 1'b1;
          st.incAddr = 1'b1;
          st.decRem  = 1'b1;
          nextState  = remIsOne ? S_FIN : S_BRD;
        end
      end
      S_FIN: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign seqBusy = (state != S_IDLE);

endmodule

// File: rtl/cipher_frame_seq.sv
module cipher_frame_seq
  import cfs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 128,
  parameter int HDR_WORDS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                seqBusy,
  output logic                done,
  output logic                err,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic                ramRdEn,
  input  logic [BLK_W-1:0]    ramRdData,
  output logic                ramWrEn,
  output logic [BLK_W-1:0]    ramWrData,
  output logic                engKeyLoad,
  output logic [2*BLK_W-1:0]  engKey,
  output logic [1:0]          engKeyLen,
  output logic                engDecrypt,
  output logic                engStart,
  output logic [BLK_W-1:0]    engBlockIn,
  input  logic                engBusy,
  input  logic [BLK_W-1:0]    engResult
);

  seqStrobe_t strobes;
  logic remIsZero, remIsOne, ctlIllegal;

  cfs_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .engBusy    (engBusy),
    .remIsZero  (remIsZero),
    .remIsOne   (remIsOne),
    .ctlIllegal (ctlIllegal),
    .st         (strobes),
    .ramRdEn    (ramRdEn),
    .ramWrEn    (ramWrEn),
    .engKeyLoad (engKeyLoad),
    .engStart   (engStart),
    .done       (done),
    .seqBusy    (seqBusy)
  );

  cfs_datapath #(
    .ADDR_W    (ADDR_W),
    .BLK_W     (BLK_W),
    .HDR_WORDS (HDR_WORDS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (strobes),
    .ramRdData  (ramRdData),
    .ramAddr    (ramAddr),
    .keyOut     (engKey),
    .keyLenOut  (engKeyLen),
    .decryptOut (engDecrypt),
    .errOut     (err),
    .remIsZero  (remIsZero),
    .remIsOne   (remIsOne),
    .ctlIllegal (ctlIllegal)
  );

  assign engBlockIn = ramRdData;
  assign ramWrData  = engResult;

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int ADDR_W    = 8,
  parameter int HDR_WORDS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              seqBusy,
  input logic              done,
  input logic              err,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramRdEn,
  input logic              ramWrEn,
  input logic              engKeyLoad,
  input logic              engStart,
  input logic              engBusy
);

  logic [ADDR_W-1:0] lastRdAddr;
  logic              keyLoaded;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRdAddr <= '0;
      keyLoaded  <= 1'b0;
    end else begin
      if (ramRdEn) lastRdAddr <= ramAddr;
      if (engKeyLoad)  keyLoaded <= 1'b1;
      else if (done)   keyLoaded <= 1'b0;
    end
  end

  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRdEn && ramWrEn));

  assert_no_header_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (int'(ramAddr) >= HDR_WORDS));

  assert_write_in_place_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (ramAddr == lastRdAddr));

  assert_start_engine_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> (!engBusy && !engKeyLoad));

  assert_key_before_block_R2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> keyLoaded);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !seqBusy);

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done);

endmodule

bind cipher_frame_seq cfs_checker #(
  .ADDR_W    (ADDR_W),
  .HDR_WORDS (HDR_WORDS)
) u_cfs_checker (
  .clk        (clk),
  .rstN       (rstN),
  .seqBusy    (seqBusy),
  .done       (done),
  .err        (err),
  .ramAddr    (ramAddr),
  .ramRdEn    (ramRdEn),
  .ramWrEn    (ramWrEn),
  .engKeyLoad (engKeyLoad),
  .engStart   (engStart),
  .engBusy    (engBusy)
);

// File: tb/test_cipher_frame_seq.sv
`timescale 1ns/1ps
module test_cipher_frame_seq;

  localparam int ADDR_W = 8;
  localparam int BLK_W  = 128;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LAT    = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic seqBusy, done, err;
  logic [ADDR_W-1:0] ramAddr;
  logic ramRdEn, ramWrEn;
  logic [BLK_W-1:0] ramRdData, ramWrData;
  logic engKeyLoad, engDecrypt, engStart;
  logic [2*BLK_W-1:0] engKey;
  logic [1:0] engKeyLen;
  logic [BLK_W-1:0] engBlockIn, engResult;
  logic engBusy;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  cipher_frame_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .HDR_WORDS(3)) i_cipher_frame_seq (
    .clk(clk), .rstN(rstN), .start(start), .seqBusy(seqBusy), .done(done), .err(err),
    .ramAddr(ramAddr), .ramRdEn(ramRdEn), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn), .ramWrData(ramWrData),
    .engKeyLoad(engKeyLoad), .engKey(engKey), .engKeyLen(engKeyLen),
    .engDecrypt(engDecrypt), .engStart(engStart), .engBlockIn(engBlockIn),
    .engBusy(engBusy), .engResult(engResult)
  );

  // local RAM model: one-cycle read latency
  logic [BLK_W-1:0] mem  [DEPTH];
  logic [BLK_W-1:0] orig [DEPTH];
  always @(posedge clk) begin
    if (ramWrEn) mem[ramAddr] <= ramWrData;
    if (ramRdEn) ramRdData <= mem[ramAddr];
  end

  function automatic logic [BLK_W-1:0] cipherModel(logic [BLK_W-1:0] blk,
      logic [2*BLK_W-1:0] key, logic [1:0] len, logic dec);
    logic [BLK_W-1:0] mix;
    mix = key[BLK_W-1:0] ^ (key[2*BLK_W-1:BLK_W] << 1) ^ {{(BLK_W-2){1'b0}}, len};
    return dec ? (blk - mix) : (blk + mix);
  endfunction

  // engine model
  logic [2*BLK_W-1:0] mKey;
  logic [1:0] mLen;
  logic mDec;
  int mCnt;
  always @(posedge clk) begin
    if (!rstN) begin
      engBusy <= 1'b0;
      mCnt <= 0;
      engResult <= '0;
    end else if (engKeyLoad) begin
      mKey <= engKey; mLen <= engKeyLen; mDec <= engDecrypt;
      engBusy <= 1'b1; mCnt <= LAT;
    end else if (engStart) begin
      engResult <= cipherModel(engBlockIn, mKey, mLen, mDec);
      engBusy <= 1'b1; mCnt <= LAT;
    end else if (engBusy) begin
      mCnt <= mCnt - 1;
      if (mCnt == 1) engBusy <= 1'b0;
    end
  end

  task automatic check(bit ok, string req, string what, logic [BLK_W-1:0] act, logic [BLK_W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runFrame(int seed, logic [1:0] len, bit dec, int n, bit midStart, string req);
    logic [2*BLK_W-1:0] key;
    logic [BLK_W-1:0] ctl;
    int cyc;
    int doneCount;
    int expCyc;
    bit illegal;
    bit untouchedOk;
    key = {32'h1000_0000 + seed, 96'hA5A5_0F0F_3C3C_9696_C3C3_5A5A, 32'h2000_0000 ^ seed,
           96'h0123_4567_89AB_CDEF_FEDC_BA98};
    for (int i = 0; i < DEPTH; i++)
      mem[i] = {32'(i * 7 + seed), 32'(seed * 131 + i), 32'hDEAD_0000 + 32'(i), 32'(i ^ seed)};
    ctl = '0;
    ctl[1:0] = len;
    ctl[4] = dec;
    ctl[23:16] = 8'(n);
    mem[0] = key[BLK_W-1:0];
    mem[1] = key[2*BLK_W-1:BLK_W];
    mem[2] = ctl;
    for (int i = 0; i < DEPTH; i++) orig[i] = mem[i];
    illegal = (len == 2'b11) || (n > DEPTH - 3);
    expCyc = illegal ? 5 : (LAT + 7 + n * (LAT + 3));

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 1;
    doneCount = 0;
    while (cyc < 5000) begin
      if (done) begin
        doneCount++;
        break;
      end
      if (midStart && cyc == 20) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(doneCount == 1 && cyc == expCyc, req, "done cycle", BLK_W'(cyc), BLK_W'(expCyc));
    check(err == illegal, illegal ? "R7/R8" : "R9", "err flag", BLK_W'(err), BLK_W'(illegal));
    check(seqBusy == 1'b1, "R9", "busy at done", BLK_W'(seqBusy), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) doneCount++;
    end
    check(doneCount == 1 && !seqBusy, "R10", "single done then idle", BLK_W'(doneCount), 1);
    check(err == illegal, "R9", "err held", BLK_W'(err), BLK_W'(illegal));
    if (!illegal) begin
      for (int b = 0; b < n; b++)
        check(mem[3 + b] == cipherModel(orig[3 + b], key, len, dec), "R3 R4",
              "block result", mem[3 + b], cipherModel(orig[3 + b], key, len, dec));
    end
    untouchedOk = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      if ((illegal || i < 3 || i >= 3 + n) && mem[i] != orig[i]) untouchedOk = 1'b0;
    check(untouchedOk, illegal ? "R7 R8" : "R3 R6", "untouched words", BLK_W'(untouchedOk), 1);
  endtask

  initial begin
    #(200000 * 5);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!seqBusy && !done && !err && !ramWrEn && !ramRdEn && !engKeyLoad && !engStart,
          "R11", "reset outputs", {seqBusy, done, err, ramWrEn, ramRdEn, engKeyLoad, engStart}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!seqBusy && !done, "R11", "idle after reset", {seqBusy, done}, 0);

    // R1 R5 R6: sweep legal codes, both directions, several counts
    for (int l = 0; l < 3; l++)
      for (int d = 0; d < 2; d++) begin
        runFrame(l * 10 + d, 2'(l), d[0], 0, 1'b0, "R6");
        runFrame(l * 10 + d + 1, 2'(l), d[0], 1, 1'b0, "R1 R5");
        runFrame(l * 10 + d + 2, 2'(l), d[0], 2, 1'b0, "R5");
        runFrame(l * 10 + d + 3, 2'(l), d[0], 5, 1'b0, "R4 R5");
      end
    // R8 boundary: largest legal count, then one past it
    runFrame(77, 2'b10, 1'b1, 253, 1'b0, "R8 R5");
    runFrame(78, 2'b00, 1'b0, 254, 1'b0, "R8");
    runFrame(79, 2'b01, 1'b1, 255, 1'b0, "R8");
    // R7 illegal key-length code
    runFrame(80, 2'b11, 1'b0, 2, 1'b0, "R7");
    // R10 start while busy
    runFrame(81, 2'b01, 1'b0, 3, 1'b1, "R10");
    // err cleared by next legal start (R9)
    runFrame(82, 2'b00, 1'b1, 1, 1'b0, "R9");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule